// File: doc/BRIEF.md
# Software Exception Entry Sequencer

This block performs the context save that precedes a software exception handler. A single-cycle request pulse tells the sequencer to latch the program counter, the status word, the stack pointer and a board-mode strap. It then pushes the return address and the status word onto the stack through a simple memory write port. When the strap was set, it also writes a system-error marker byte into a control register. After that it presents the new PC, SP and status word to the core.

The write port carries a byte address, a 32-bit little-endian data bus, per-lane byte enables and a valid/ready handshake. Each write stays on the port until the memory side accepts it. A request that arrives while a sequence is running never starts a nested one. It sets a sticky error flag instead, which only reset clears.

Top module: `exc_entry_seq`

## Requirements
- R1: After synchronous active-high reset: `busy_o`, `done_o`, `mem_valid_o` and `recursion_err_o` are 0, and `pc_o`, `sp_o` and `psw_o` are 0.
- R2: In the cycle after a request is accepted from idle, the first write is on the port. It carries the latched PC as a full word at address SP-4, with all four byte enables set (4'b1111).
- R3: The second write carries the latched status word as a halfword at address SP-8. Bus byte lane k carries address base+k, so for a word-aligned SP the halfword sits in bits 15:0, the enables are 4'b0011 and bits 31:16 are 0.
- R4: When the strap was 1 at the request, a third write follows. It carries byte 0x04 at address 0x34000103, on lane 3: enables 4'b1000, data 0x04000000. When the strap was 0, no third write occurs. Changes to the strap after the request have no effect.
- R5: A write holds valid, address, data and enables unchanged until `mem_ready_i` is high at a clock edge, and the next step starts only after that edge.
- R6: With `done_o`, `pc_o` = 0x40000008, `sp_o` = latched SP − 8, and `psw_o` = latched status word with bit 11 (interrupt enable) cleared and all other bits kept.
- R7: `busy_o` is high from the cycle after acceptance until `done_o`. `done_o` is high for exactly one cycle, one cycle after the last write is accepted, and `busy_o` is already low in that cycle.
- R8: A request while `busy_o` is high starts no new sequence and leaves the running writes and results unchanged. It sets `recursion_err_o`, which stays set until reset.
- R9: A request in the cycle where `done_o` is high is accepted as a fresh sequence and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Exception request pulse |
| pc_i | input | 32 | Current program counter |
| psw_i | input | 16 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| board_mode_i | input | 1 | Strap enabling the error-marker write |
| mem_addr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data, little-endian lanes |
| mem_be_o | output | 4 | Byte enables |
| mem_valid_o | output | 1 | Write request valid |
| mem_ready_i | input | 1 | Write accepted at this edge |
| pc_o | output | 32 | New program counter |
| sp_o | output | 32 | New stack pointer |
| psw_o | output | 16 | New status word |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Sequence in progress |
| recursion_err_o | output | 1 | Sticky nested-request flag |

## Verification
The bench builds the block with its default parameters: a 32-bit address and data bus with four byte lanes, a 16-bit status word with the interrupt-enable bit at position 11, and the fixed vector and marker address. This places the byte write on the highest lane and the halfword on the lowest. Lane selection is therefore exercised at both ends of the bus. Ready delays of zero to three cycles, strap toggling after acceptance, a request injected mid-sequence, and a request in the completion cycle cover the handshake, latching and nesting rules.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PC,
    ST_WR_PSW,
    ST_WR_FLAG,
    ST_APPLY
  } seq_state_e;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trig_i,
  input  logic       board_q_i,
  input  logic       mem_ready_i,
  output seq_state_e state_o,
  output logic       capture_o,
  output logic       apply_o,
  output logic       mem_valid_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  seq_state_e state_q;

  assign capture_o   = (state_q == ST_IDLE) && trig_i;
  assign apply_o     = (state_q == ST_APPLY);
  assign busy_o      = (state_q != ST_IDLE);
  assign mem_valid_o = (state_q == ST_WR_PC) || (state_q == ST_WR_PSW) ||
                       (state_q == ST_WR_FLAG);
  assign state_o     = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (trig_i && busy_o) err_o <= 1'b1;
      case (state_q)
        ST_IDLE:    if (trig_i) state_q <= ST_WR_PC;
        ST_WR_PC:   if (mem_ready_i) state_q <= ST_WR_PSW;
        ST_WR_PSW:  if (mem_ready_i) state_q <= board_q_i ? ST_WR_FLAG : ST_APPLY;
        ST_WR_FLAG: if (mem_ready_i) state_q <= ST_APPLY;
        ST_APPLY: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default:    state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_ctx.sv
module exc_entry_ctx #(
  parameter int                  ADDR_W = 32,
  parameter int                  PSW_W  = 16,
  parameter int                  IE_POS = 11,
  parameter logic [ADDR_W-1:0]   VECTOR = 'h4000_0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic              apply_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [PSW_W-1:0]  psw_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              board_i,
  output logic [ADDR_W-1:0] pc_q_o,
  output logic [PSW_W-1:0]  psw_q_o,
  output logic [ADDR_W-1:0] sp_q_o,
  output logic              board_q_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [PSW_W-1:0]  psw_o
);
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(8);
  localparam logic [PSW_W-1:0]  IE_MASK     = PSW_W'(1) << IE_POS;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q_o    <= '0;
      psw_q_o   <= '0;
      sp_q_o    <= '0;
      board_q_o <= 1'b0;
      pc_o      <= '0;
      sp_o      <= '0;
      psw_o     <= '0;
    end else begin
      if (capture_i) begin
        pc_q_o    <= pc_i;
        psw_q_o   <= psw_i;
        sp_q_o    <= sp_i;
        board_q_o <= board_i;
      end
      if (apply_i) begin
        pc_o  <= VECTOR;
        sp_o  <= sp_q_o - FRAME_BYTES;
        psw_o <= psw_q_o & ~IE_MASK;
      end
    end
  end
endmodule

// File: rtl/exc_entry_wport.sv
module exc_entry_wport
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                PSW_W     = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h3400_0103,
  parameter logic [7:0]        FLAG_VAL  = 8'h04
) (
  input  seq_state_e          state_i,
  input  logic [ADDR_W-1:0]   pc_q_i,
  input  logic [PSW_W-1:0]    psw_q_i,
  input  logic [ADDR_W-1:0]   sp_q_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [DATA_W/8-1:0] be_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int CNT_W = OFF_W + 1;

  logic [DATA_W-1:0] value;
  logic [CNT_W-1:0]  nbytes;
  logic [DATA_W-1:0] shifted;
  logic [OFF_W-1:0]  off;

  always_comb begin
    addr_o = '0;
    value  = '0;
    nbytes = '0;
    case (state_i)
      ST_WR_PC: begin
        addr_o = sp_q_i - ADDR_W'(4);
        value  = DATA_W'(pc_q_i);
        nbytes = CNT_W'(4);
      end
      ST_WR_PSW: begin
        addr_o = sp_q_i - ADDR_W'(8);
        value  = DATA_W'(psw_q_i);
        nbytes = CNT_W'(2);
      end
      ST_WR_FLAG: begin
        addr_o = FLAG_ADDR;
        value  = DATA_W'(FLAG_VAL);
        nbytes = CNT_W'(1);
      end
      default: ;
    endcase
  end

  assign off     = addr_o[OFF_W-1:0];
  assign shifted = value << (8 * int'(off));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_en;
    assign lane_en            = (k >= int'(off)) && (k < int'(off) + int'(nbytes));
    assign be_o[k]            = lane_en;
    assign data_o[8*k +: 8]   = lane_en ? shifted[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                PSW_W     = 16,
  parameter int                IE_POS    = 11,
  parameter logic [ADDR_W-1:0] VECTOR    = 'h4000_0008,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h3400_0103,
  parameter logic [7:0]        FLAG_VAL  = 8'h04
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [PSW_W-1:0]    psw_i,
  input  logic [ADDR_W-1:0]   sp_i,
  input  logic                board_mode_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic                mem_valid_o,
  input  logic                mem_ready_i,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [ADDR_W-1:0]   sp_o,
  output logic [PSW_W-1:0]    psw_o,
  output logic                done_o,
  output logic                busy_o,
  output logic                recursion_err_o
);
  seq_state_e        state;
  logic              capture, apply, board_q;
  logic [ADDR_W-1:0] pc_q, sp_q;
  logic [PSW_W-1:0]  psw_q;

  exc_entry_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .trig_i      (trig_i),
    .board_q_i   (board_q),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .capture_o   (capture),
    .apply_o     (apply),
    .mem_valid_o (mem_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (recursion_err_o)
  );

  exc_entry_ctx #(
    .ADDR_W (ADDR_W), .PSW_W (PSW_W), .IE_POS (IE_POS), .VECTOR (VECTOR)
  ) u_ctx (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture),
    .apply_i   (apply),
    .pc_i      (pc_i),
    .psw_i     (psw_i),
    .sp_i      (sp_i),
    .board_i   (board_mode_i),
    .pc_q_o    (pc_q),
    .psw_q_o   (psw_q),
    .sp_q_o    (sp_q),
    .board_q_o (board_q),
    .pc_o      (pc_o),
    .sp_o      (sp_o),
    .psw_o     (psw_o)
  );

  exc_entry_wport #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PSW_W (PSW_W),
    .FLAG_ADDR (FLAG_ADDR), .FLAG_VAL (FLAG_VAL)
  ) u_wport (
    .state_i (state),
    .pc_q_i  (pc_q),
    .psw_q_i (psw_q),
    .sp_q_i  (sp_q),
    .addr_o  (mem_addr_o),
    .data_o  (mem_wdata_o),
    .be_o    (mem_be_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int                ADDR_W = 32,
  parameter int                DATA_W = 32,
  parameter int                PSW_W  = 16,
  parameter int                IE_POS = 11,
  parameter logic [ADDR_W-1:0] VECTOR = 'h4000_0008
) (
  input logic                clk,
  input logic                rst,
  input logic                trig_i,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [DATA_W-1:0]   mem_wdata_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic                mem_valid_o,
  input logic                mem_ready_i,
  input logic [ADDR_W-1:0]   pc_o,
  input logic [PSW_W-1:0]    psw_o,
  input logic                done_o,
  input logic                busy_o,
  input logic                recursion_err_o
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
                                    $stable(mem_wdata_o) && $stable(mem_be_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_valid_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_valid_o |-> busy_o);

  assert_vector_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pc_o == VECTOR) && !psw_o[IE_POS]);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(recursion_err_o) |-> $past(trig_i && busy_o));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    recursion_err_o |=> recursion_err_o);
endmodule

bind exc_entry_seq exc_entry_chk #(
  .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PSW_W (PSW_W),
  .IE_POS (IE_POS), .VECTOR (VECTOR)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .trig_i          (trig_i),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o),
  .mem_be_o        (mem_be_o),
  .mem_valid_o     (mem_valid_o),
  .mem_ready_i     (mem_ready_i),
  .pc_o            (pc_o),
  .psw_o           (psw_o),
  .done_o          (done_o),
  .busy_o          (busy_o),
  .recursion_err_o (recursion_err_o)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [15:0] psw_i = '0;
  logic [31:0] sp_i = '0;
  logic        board_mode_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, pc_o, sp_o;
  logic [3:0]  mem_be_o;
  logic        mem_valid_o, mem_ready_i = 1'b0;
  logic [15:0] psw_o;
  logic        done_o, busy_o, recursion_err_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk (clk), .rst (rst), .trig_i (trig_i), .pc_i (pc_i), .psw_i (psw_i),
    .sp_i (sp_i), .board_mode_i (board_mode_i), .mem_addr_o (mem_addr_o),
    .mem_wdata_o (mem_wdata_o), .mem_be_o (mem_be_o), .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i), .pc_o (pc_o), .sp_o (sp_o), .psw_o (psw_o),
    .done_o (done_o), .busy_o (busy_o), .recursion_err_o (recursion_err_o)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // entered just after a negedge; returns after a negedge with WR_PC visible
  task automatic start(input logic [31:0] pc, input logic [15:0] psw,
                       input logic [31:0] sp, input logic board);
    pc_i = pc; psw_i = psw; sp_i = sp; board_mode_i = board; trig_i = 1'b1;
    step();
    trig_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after accept", 64'(busy_o), 64'd1);
  endtask

  task automatic expect_write(input logic [31:0] addr, input logic [31:0] data,
                              input logic [3:0] be, input int delay,
                              input logic inject, input string req);
    chk(mem_valid_o == 1'b1, {req, " valid"}, 64'(mem_valid_o), 64'd1);
    chk(mem_addr_o == addr, {req, " addr"}, 64'(mem_addr_o), 64'(addr));
    chk(mem_wdata_o == data, {req, " data"}, 64'(mem_wdata_o), 64'(data));
    chk(mem_be_o == be, {req, " be"}, 64'(mem_be_o), 64'(be));
    for (int i = 0; i < delay; i++) begin
      if (inject && i == 0) begin
        trig_i = 1'b1; pc_i = 32'hFFFF_FFFF; psw_i = 16'hFFFF;
        sp_i = 32'h0000_0100; board_mode_i = 1'b1;
      end
      step();
      trig_i = 1'b0;
      if (inject && i == 0)
        chk(recursion_err_o == 1'b1, "R8 error raised", 64'(recursion_err_o), 64'd1);
      chk(mem_valid_o && mem_addr_o == addr && mem_wdata_o == data && mem_be_o == be,
          "R5 held while not ready", 64'(mem_addr_o), 64'(addr));
    end
    mem_ready_i = 1'b1;
    step();
    mem_ready_i = 1'b0;
  endtask

  // at the apply cycle; returns at the negedge where done_o is high
  task automatic expect_finish(input logic [31:0] pc, input logic [31:0] sp,
                               input logic [15:0] psw);
    chk(mem_valid_o == 1'b0, "R4 no further write", 64'(mem_valid_o), 64'd0);
    chk(busy_o == 1'b1 && done_o == 1'b0, "R7 busy in apply cycle",
        64'({busy_o, done_o}), 64'h2);
    step();
    chk(done_o == 1'b1 && busy_o == 1'b0, "R7 done with busy low",
        64'({busy_o, done_o}), 64'h1);
    chk(pc_o == pc, "R6 vector", 64'(pc_o), 64'(pc));
    chk(sp_o == sp, "R6 sp minus 8", 64'(sp_o), 64'(sp));
    chk(psw_o == psw, "R6 ie cleared", 64'(psw_o), 64'(psw));
  endtask

  task automatic expect_quiet();
    step();
    chk(done_o == 1'b0 && mem_valid_o == 1'b0, "R7 done one cycle",
        64'({done_o, mem_valid_o}), 64'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    chk(!busy_o && !done_o && !mem_valid_o && !recursion_err_o, "R1 flags",
        64'({busy_o, done_o, mem_valid_o, recursion_err_o}), 64'h0);
    chk(pc_o == 0 && sp_o == 0 && psw_o == 0, "R1 outputs",
        64'(pc_o | sp_o), 64'h0);
  endtask

  task automatic t_plain();
    start(32'h1234_5678, 16'h0F0F, 32'h0000_8000, 1'b0);
    board_mode_i = 1'b1;   // late strap change must be ignored (R4)
    expect_write(32'h0000_7FFC, 32'h1234_5678, 4'hF, 0, 1'b0, "R2 pc word");
    expect_write(32'h0000_7FF8, 32'h0000_0F0F, 4'h3, 2, 1'b0, "R3 psw half");
    expect_finish(32'h4000_0008, 32'h0000_7FF8, 16'h070F);
    chk(recursion_err_o == 1'b0, "R8 no error", 64'(recursion_err_o), 64'd0);
    expect_quiet();
  endtask

  task automatic t_board();
    start(32'hCAFE_0010, 16'h8801, 32'h0010_0000, 1'b1);
    board_mode_i = 1'b0;   // strap latched at request (R4)
    expect_write(32'h000F_FFFC, 32'hCAFE_0010, 4'hF, 3, 1'b0, "R2 pc word");
    expect_write(32'h000F_FFF8, 32'h0000_8801, 4'h3, 1, 1'b0, "R3 psw half");
    expect_write(32'h3400_0103, 32'h0400_0000, 4'h8, 2, 1'b0, "R4 marker byte");
    expect_finish(32'h4000_0008, 32'h000F_FFF8, 16'h8001);
    expect_quiet();
  endtask

  task automatic t_nested();
    start(32'h0000_0100, 16'h0800, 32'h0000_2000, 1'b0);
    expect_write(32'h0000_1FFC, 32'h0000_0100, 4'hF, 2, 1'b1, "R8 pc word kept");
    expect_write(32'h0000_1FF8, 32'h0000_0800, 4'h3, 0, 1'b0, "R8 psw half kept");
    expect_finish(32'h4000_0008, 32'h0000_1FF8, 16'h0000);
    expect_quiet();
    chk(recursion_err_o == 1'b1, "R8 error sticky", 64'(recursion_err_o), 64'd1);
    do_reset();
  endtask

  task automatic t_back_to_back();
    start(32'h0000_4444, 16'hFFFF, 32'h0000_0400, 1'b0);
    expect_write(32'h0000_03FC, 32'h0000_4444, 4'hF, 0, 1'b0, "R2 pc word");
    expect_write(32'h0000_03F8, 32'h0000_FFFF, 4'h3, 0, 1'b0, "R3 psw half");
    expect_finish(32'h4000_0008, 32'h0000_03F8, 16'hF7FF);
    start(32'h0000_5555, 16'h0001, 32'h0000_0800, 1'b0);
    chk(recursion_err_o == 1'b0, "R9 no error at done", 64'(recursion_err_o), 64'd0);
    expect_write(32'h0000_07FC, 32'h0000_5555, 4'hF, 1, 1'b0, "R9 fresh pc word");
    expect_write(32'h0000_07F8, 32'h0000_0001, 4'h3, 0, 1'b0, "R9 fresh psw half");
    expect_finish(32'h4000_0008, 32'h0000_07F8, 16'h0001);
    expect_quiet();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_plain();
    t_board();
    t_nested();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule